// File: doc/BRIEF.md
# Bridge Data Parity Error Reporter

This block decides how a two-port PCI-to-PCI bridge reports data parity errors. It looks at one data phase per clock. For each phase it is told the transaction kind, which way the transaction flows, and on which bus the error showed up. It also receives the secondary-bus parity error flag, the sampled secondary PERR# level, whether the bridge is the master on the secondary bus, and the parity-error-response enables of the two interfaces.

The block has two outputs. The first is the active-low primary PERR# pin, which pulses for one clock. The second is a sticky status bit that records a master data parity error on the secondary interface. Software clears that bit by writing a 1 to it.

An error can cross from one bus to the other. If the secondary PERR# is seen while a downstream delayed write completes on the secondary bus, the bridge reports it on the primary bus. It does so only when both response enables are set.

Top module: `bridge_perr_reporter`

## Requirements
- R1: While a synchronous reset is applied, and in the first cycle after it, `p_perr_n` is high and `sec_mdpe` is 0.
- R2: `sec_mdpe` becomes 1 one clock after a phase in which all of the following hold: `dp_valid` is 1, `sec_master` is 1, `sec_per_en` is 1, `dir_up` is 0, `err_on_sec` is 1, and either `sec_par_err` is 1 or `s_perr_n` is 0. This applies to read (`xact`=00), posted write (01) and delayed write (10) alike. The code 11 means no transaction.
- R3: Upstream phases (`dir_up`=1) and primary-bus errors (`err_on_sec`=0) never set `sec_mdpe`. `pri_per_en` has no effect on `sec_mdpe`.
- R4: When `pri_per_en`=1 and the error is on the primary bus, `p_perr_n` pulses for an upstream read. It also pulses for a downstream posted write and for a downstream delayed write.
- R5: For a downstream delayed write with `err_on_sec`=1 and `s_perr_n`=0, `p_perr_n` pulses only if both `pri_per_en` and `sec_per_en` are 1.
- R6: Every other combination leaves `p_perr_n` high. This includes all upstream writes, downstream reads, downstream posted-write errors on the secondary bus, phases with `pri_per_en`=0, and the code `xact`=11.
- R7: A qualifying phase in cycle t drives `p_perr_n` low during cycle t+2 only. Each phase gives at most one low cycle.
- R8: `sec_mdpe` stays set until a clock with `cfg_wr`=1 and `cfg_wdata[STAT_BIT]`=1, which clears it. A write with that bit at 0 leaves it set.
- R9: If a clearing write and a set condition occur in the same cycle, `sec_mdpe` ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dp_valid | input | 1 | Current cycle holds a data phase to evaluate |
| xact | input | 2 | 00 read, 01 posted write, 10 delayed write, 11 none |
| dir_up | input | 1 | 1 = upstream, 0 = downstream |
| err_on_sec | input | 1 | Error was found on the secondary bus (0 = primary) |
| sec_par_err | input | 1 | Data parity error found on the secondary bus |
| s_perr_n | input | 1 | Sampled secondary PERR#, active low |
| sec_master | input | 1 | Bridge is master on the secondary bus |
| pri_per_en | input | 1 | Primary parity-error-response enable |
| sec_per_en | input | 1 | Secondary parity-error-response enable |
| cfg_wr | input | 1 | Configuration write to the status word |
| cfg_wdata | input | CFG_W | Configuration write data |
| p_perr_n | output | 1 | Primary PERR#, active low |
| sec_mdpe | output | 1 | Sticky secondary master data parity error bit |

## Verification
The bench builds the block with the default values, a 16-bit configuration word with the status bit at position 8. Bits on both sides of that position therefore exist, and writes that set only neighbouring bits can be shown to leave the status untouched. Random phases cover the whole decode table, including back-to-back qualifying phases. Directed cases cover the cross-bus path with each single enable, and a clearing write that lands on a set condition.

// File: rtl/bridge_perr_reporter.sv
module bridge_perr_reporter #(
  parameter int CFG_W    = 16,
  parameter int STAT_BIT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dp_valid,
  input  logic [1:0]       xact,
  input  logic             dir_up,
  input  logic             err_on_sec,
  input  logic             sec_par_err,
  input  logic             s_perr_n,
  input  logic             sec_master,
  input  logic             pri_per_en,
  input  logic             sec_per_en,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             p_perr_n,
  output logic             sec_mdpe
);
  localparam logic [1:0] XT_RD = 2'd0, XT_PW = 2'd1, XT_DW = 2'd2;

  wire down     = !dir_up;
  wire is_wr    = (xact == XT_PW) || (xact == XT_DW);
  wire pri_hit  = dp_valid && pri_per_en && !err_on_sec &&
                  (((xact == XT_RD) && dir_up) || (is_wr && down));
  wire xbus_hit = dp_valid && pri_per_en && sec_per_en && err_on_sec &&
                  down && (xact == XT_DW) && !s_perr_n;
  wire set_mdpe = dp_valid && sec_master && sec_per_en && down && err_on_sec &&
                  (xact != 2'd3) && (sec_par_err || !s_perr_n);
  wire clr_mdpe = cfg_wr && cfg_wdata[STAT_BIT];

  logic hit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q    <= 1'b0;
      p_perr_n <= 1'b1;
      sec_mdpe <= 1'b0;
    end else begin
      hit_q    <= pri_hit || xbus_hit;
      p_perr_n <= !hit_q;
      sec_mdpe <= set_mdpe || (sec_mdpe && !clr_mdpe);
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk) rst |=> (p_perr_n && !sec_mdpe));

  a_r7_pulse_source: assert property (@(posedge clk) disable iff (rst)
    !p_perr_n |-> ($past(dp_valid, 2) && $past(pri_per_en, 2)));

  a_r6_upstream_write_quiet: assert property (@(posedge clk) disable iff (rst)
    (dp_valid && dir_up && (xact != XT_RD)) |=> ##1 p_perr_n);

  a_r3_set_needs_sec_side: assert property (@(posedge clk) disable iff (rst)
    $rose(sec_mdpe) |-> ($past(sec_per_en) && $past(sec_master) && !$past(dir_up) && $past(err_on_sec)));

  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    (sec_mdpe && !(cfg_wr && cfg_wdata[STAT_BIT])) |=> sec_mdpe);

  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_wdata[STAT_BIT] && !dp_valid) |=> !sec_mdpe);
endmodule

// File: tb/bridge_perr_reporter_test.sv
module bridge_perr_reporter_test;
  localparam int CLK_P = 10;
  localparam int CFG_W = 16;
  localparam int SBIT  = 8;

  logic clk = 0, rst = 1;
  logic dp_valid = 0, dir_up = 0, err_on_sec = 0, sec_par_err = 0, s_perr_n = 1;
  logic sec_master = 0, pri_per_en = 0, sec_per_en = 0, cfg_wr = 0;
  logic [1:0] xact = 2'd3;
  logic [CFG_W-1:0] cfg_wdata = '0;
  logic p_perr_n, sec_mdpe;

  int n_chk = 0, n_fail = 0;
  logic m_hit = 0, m_out = 1, m_stat = 0;

  always #(CLK_P/2) clk = ~clk;

  bridge_perr_reporter #(.CFG_W(CFG_W), .STAT_BIT(SBIT)) uut (
    .clk(clk), .rst(rst), .dp_valid(dp_valid), .xact(xact), .dir_up(dir_up),
    .err_on_sec(err_on_sec), .sec_par_err(sec_par_err), .s_perr_n(s_perr_n),
    .sec_master(sec_master), .pri_per_en(pri_per_en), .sec_per_en(sec_per_en),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .p_perr_n(p_perr_n), .sec_mdpe(sec_mdpe));

  function automatic logic exp_hit();
    logic pr, xb;
    pr = !err_on_sec && ((xact == 2'd0 && dir_up) || ((xact == 2'd1 || xact == 2'd2) && !dir_up));
    xb = err_on_sec && !dir_up && xact == 2'd2 && sec_per_en && !s_perr_n;
    return dp_valid && pri_per_en && (pr || xb);
  endfunction

  function automatic logic exp_set();
    return dp_valid && sec_master && sec_per_en && !dir_up && err_on_sec &&
           xact != 2'd3 && (sec_par_err || !s_perr_n);
  endfunction

  task automatic check(string tag, logic act, logic exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic tick(string tag);
    if (rst) begin
      m_hit = 0; m_out = 1; m_stat = 0;
    end else begin
      m_out  = !m_hit;
      m_hit  = exp_hit();
      m_stat = exp_set() || (m_stat && !(cfg_wr && cfg_wdata[SBIT]));
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, p_perr_n, m_out, "p_perr_n");
    check(tag, sec_mdpe, m_stat, "sec_mdpe");
  endtask

  task automatic idle();
    dp_valid = 0; cfg_wr = 0; cfg_wdata = '0; xact = 2'd3;
  endtask

  task automatic phase(logic [1:0] t, logic up, logic onsec, logic spe, logic sp_n,
                       logic mst, logic pe, logic se);
    dp_valid = 1; xact = t; dir_up = up; err_on_sec = onsec; sec_par_err = spe;
    s_perr_n = sp_n; sec_master = mst; pri_per_en = pe; sec_per_en = se;
  endtask

  task automatic clear_write(logic [CFG_W-1:0] d);
    cfg_wr = 1; cfg_wdata = d;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    tick("R1"); tick("R1");
    rst = 0;
    tick("R1");

    // R4 upstream read, primary error
    phase(2'd0, 1, 0, 0, 1, 0, 1, 0); tick("R4"); idle(); tick("R7");
    check("R7", p_perr_n, 1'b0, "low two clocks after phase");
    tick("R7");
    check("R7", p_perr_n, 1'b1, "single low cycle");
    // R4 downstream posted write and delayed write, primary
    phase(2'd1, 0, 0, 0, 1, 0, 1, 0); tick("R4");
    phase(2'd2, 0, 0, 0, 1, 0, 1, 0); tick("R4"); idle(); tick("R4"); tick("R4");
    // R5 cross-bus with each enable combination
    phase(2'd2, 0, 1, 0, 0, 0, 1, 1); tick("R5"); idle(); tick("R5");
    check("R5", p_perr_n, 1'b0, "cross-bus both enables");
    phase(2'd2, 0, 1, 0, 0, 0, 1, 0); tick("R5"); idle(); tick("R5"); tick("R5");
    phase(2'd2, 0, 1, 0, 0, 0, 0, 1); tick("R5"); idle(); tick("R5"); tick("R5");
    // R6 quiet cases
    phase(2'd1, 1, 0, 0, 0, 0, 1, 1); tick("R6");
    phase(2'd0, 0, 0, 0, 0, 0, 1, 1); tick("R6");
    phase(2'd1, 0, 1, 1, 0, 0, 1, 1); tick("R6");
    phase(2'd3, 1, 0, 0, 0, 0, 1, 1); tick("R6"); idle(); tick("R6"); tick("R6");
    // R3 status not set: upstream, primary bus, pri enable only
    phase(2'd0, 1, 1, 1, 0, 1, 1, 1); tick("R3");
    phase(2'd1, 0, 0, 1, 0, 1, 1, 1); tick("R3");
    phase(2'd0, 0, 1, 1, 1, 1, 1, 0); tick("R3"); idle(); tick("R3");
    check("R3", sec_mdpe, 1'b0, "status untouched");
    // R2 set via s_perr_n, R8 sticky and clear
    phase(2'd0, 0, 1, 0, 0, 1, 0, 1); tick("R2"); idle(); tick("R2");
    check("R2", sec_mdpe, 1'b1, "set by secondary PERR#");
    clear_write(16'hFEFF); tick("R8");
    check("R8", sec_mdpe, 1'b1, "neighbour bits do not clear");
    clear_write(16'h0100); tick("R8");
    check("R8", sec_mdpe, 1'b0, "write-one clears");
    // R9 set wins over clear
    phase(2'd1, 0, 1, 1, 1, 1, 0, 1); clear_write(16'h0100); tick("R9");
    check("R9", sec_mdpe, 1'b1, "set beats clear");
    idle(); tick("R9");

    for (int i = 0; i < 2000; i++) begin
      phase(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom));
      dp_valid = ($urandom % 4) != 0;
      cfg_wr = ($urandom % 6) == 0;
      cfg_wdata = 16'($urandom);
      tick("R7");
    end
    idle(); tick("R7"); tick("R7");
    rst = 1; tick("R1"); rst = 0; tick("R1");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule